// File: doc/BRIEF.md
# Handshaked Byte-Bus Register Slave

This block is the device-side end of an asynchronous 8-bit parallel link over which a host microcontroller reads and writes registers held in peripheral logic. The host owns four control lines: a transaction-active line, a direction line, a request strobe and a reset line. The slave answers on two return lines: a handshake response and a transaction-complete flag. Every byte crosses the link under a four-phase request/response handshake. The slave samples all host lines through synchronisers and acts only on the synchronised edges, so the host may run at any speed.

A transaction opens with six bytes from the host. These are a command byte, a register-number byte and a 32-bit argument sent least-significant byte first. The slave then performs one access on its internal register port. After that it returns a 32-bit reply word, least-significant byte first. When the parameter `STATUS_EN` is set, a 32-bit status word follows the reply word, so the host reads eight bytes instead of four. The slave drives the shared bus only while the host has selected reading during the reply phase. At all other times its output enable is low.

Top module: `byteBusSlave`

## Requirements
- R1: After reset, and while no transaction is active, hostHs2, hostAck and busOe are all 0, and neither regWr nor regRd pulses.
- R2: When command byte 0x01 (write) is received, regWr pulses high for exactly one clock and regRd does not pulse. During that pulse, regAddr carries the second byte and regWrData carries bytes 3 to 6 assembled least-significant byte first.
- R3: When command byte 0x00 (read) is received, regRd pulses high for exactly one clock and regWr does not pulse. The first four reply bytes are regRdData, as sampled during that pulse, sent least-significant byte first.
- R4: For a write command, the four-byte reply word echoes the written 32-bit value, least-significant byte first.
- R5: With STATUS_EN=1, reply bytes 5 to 8 carry regStatus, sampled at the access, least-significant byte first. The transaction then has eight reply bytes.
- R6: With STATUS_EN=0, the reply is four bytes, and hostAck rises once the fourth reply byte's handshake completes.
- R7: hostHs2 is low before each byte's request. It rises only after hostHs1 rises and falls only after hostHs1 falls, and each of these responses arrives within 40 clocks.
- R8: hostAck stays 0 until the request line falls on the final reply byte, then rises. It returns to 0 after hostStart is deasserted.
- R9: busOe is 1 only when hostStart=1, hostRw=0 (host reads) and the slave is in the reply phase. It is 0 throughout the command phase, and also in the reply phase while hostRw=1.
- R10: A command byte other than 0x00 or 0x01 produces neither regWr nor regRd, and every reply byte (including status) is 0x00.
- R11: Dropping hostStart part way through a transaction returns the slave to idle with hostHs2 low and no register access. The next transaction completes normally.
- R12: Asserting hostReset forces hostHs2 and hostAck low and returns the slave to idle, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hostStart | input | 1 | Host transaction-active line (asynchronous) |
| hostRw | input | 1 | Direction: 1 host writes, 0 host reads (asynchronous) |
| hostHs1 | input | 1 | Host byte request strobe (asynchronous) |
| hostReset | input | 1 | Host-driven return-to-idle line (asynchronous) |
| busIn | input | 8 | Byte bus as seen by the slave |
| busOut | output | 8 | Byte the slave presents on the bus |
| busOe | output | 1 | Slave bus drive enable (tri-state control) |
| hostHs2 | output | 1 | Slave handshake response |
| hostAck | output | 1 | Transaction-complete flag |
| regAddr | output | 8 | Register number for the internal access |
| regWrData | output | 32 | Write value for the internal access |
| regWr | output | 1 | One-clock register write strobe |
| regRd | output | 1 | One-clock register read strobe |
| regRdData | input | 32 | Read value, sampled during regRd |
| regStatus | input | 32 | Status word, sampled at the access |

## Verification
The bench drives the host side as a polling handshake and targets these cases:
- Byte ordering inside both words. A design that packed the bytes most-significant first would return swapped replies and misplace the write value.
- The moment hostAck rises. A slave that counted reply bytes one short would raise it while the host still expects data, and a slave that never cleared it would be seen after start drops.
- Bus direction. The bench watches busOe during the command phase and during a reply phase held in write direction, so a design that drove a contended bus would be caught.
- Abort, host reset and an unknown command. A design that did any of these wrong would leave hostHs2 high, issue a stray register strobe, or return stale data instead of zeros.

// File: rtl/byteBusPkg.sv
package byteBusPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_ACCESS,
    ST_DONE
  } stateT;

  // Control-to-datapath strobes
  typedef struct packed {
    logic capture;  // latch busIn into the byte slot selected by byteIdx
    logic access;   // perform the register access and load the reply
  } strobeT;

  localparam logic [7:0] CMD_READ  = 8'h00;
  localparam logic [7:0] CMD_WRITE = 8'h01;

endpackage

// File: rtl/byteBusSync.sv
module byteBusSync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/byteBusCtrl.sv
module byteBusCtrl
  import byteBusPkg::*;
#(
  parameter int WR_BYTES = 6,
  parameter int RD_BYTES = 8,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startS,
  input  logic             rwS,
  input  logic             hs1S,
  input  logic             resetS,
  output logic             hs2,
  output logic             ack,
  output logic             busOe,
  output logic [CNT_W-1:0] byteIdx,
  output strobeT           strobe
);

  stateT state;
  logic  replyPhase;
  logic  hs1Prev;
  logic  hs1Rise, hs1Fall, active;

  assign hs1Rise = hs1S & ~hs1Prev;
  assign hs1Fall = ~hs1S & hs1Prev;
  assign active  = startS & ~resetS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs1Prev <= 1'b0;
    else        hs1Prev <= hs1S;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      hs2        <= 1'b0;
      ack        <= 1'b0;
      byteIdx    <= '0;
      replyPhase <= 1'b0;
    end else if (!active) begin
      state      <= ST_IDLE;
      hs2        <= 1'b0;
      ack        <= 1'b0;
      byteIdx    <= '0;
      replyPhase <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          state      <= ST_WAIT_HI;
          byteIdx    <= '0;
          replyPhase <= 1'b0;
        end
        ST_WAIT_HI: begin
          if (hs1Rise) begin
            hs2   <= 1'b1;
            state <= ST_WAIT_LO;
          end
        end
        ST_WAIT_LO: begin
          if (hs1Fall) begin
            hs2 <= 1'b0;
            if (!replyPhase) begin
              if (byteIdx == CNT_W'(WR_BYTES - 1)) begin
                byteIdx <= '0;
                state   <= ST_ACCESS;
              end else begin
                byteIdx <= byteIdx + 1'b1;
                state   <= ST_WAIT_HI;
              end
            end else begin
              if (byteIdx == CNT_W'(RD_BYTES - 1)) begin
                ack   <= 1'b1;
                state <= ST_DONE;
              end else begin
                byteIdx <= byteIdx + 1'b1;
                state   <= ST_WAIT_HI;
              end
            end
          end
        end
        ST_ACCESS: begin
          replyPhase <= 1'b1;
          state      <= ST_WAIT_HI;
        end
        ST_DONE: state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture = active & (state == ST_WAIT_HI) & hs1Rise & ~replyPhase;
    strobe.access  = active & (state == ST_ACCESS);
  end

  assign busOe = active & ~rwS & replyPhase &
                 ((state == ST_WAIT_HI) | (state == ST_WAIT_LO));

  // R7
  hs2_rise_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs2) |-> $past(hs1S));

  // R7
  hs2_fall_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs2) |-> (!$past(hs1S) || !$past(startS) || $past(resetS)));

  // R8
  ack_clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) |-> (!$past(startS) || $past(resetS)));

  // R9
  bus_drive_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busOe |-> (startS && !rwS && !resetS));

  // R12
  host_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resetS |=> (!hs2 && !ack));

endmodule

// File: rtl/byteBusData.sv
module byteBusData
  import byteBusPkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int STATUS_EN  = 1,
  parameter int RD_BYTES   = 8,
  parameter int CNT_W      = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  strobeT                  strobe,
  input  logic [CNT_W-1:0]        byteIdx,
  input  logic [7:0]              busIn,
  output logic [7:0]              busOut,
  output logic [7:0]              regAddr,
  output logic [8*WORD_BYTES-1:0] regWrData,
  output logic                    regWr,
  output logic                    regRd,
  input  logic [8*WORD_BYTES-1:0] regRdData,
  input  logic [8*WORD_BYTES-1:0] regStatus
);

  localparam int DW = 8 * WORD_BYTES;

  logic [7:0]          cmdQ;
  logic [7:0]          addrQ;
  logic [DW-1:0]       wdataQ;
  logic [DW-1:0]       dataWord;
  logic [DW-1:0]       dataNext;
  logic [8*RD_BYTES-1:0] replyAll;
  logic                cmdKnown;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdQ   <= '0;
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strobe.capture) begin
      if (byteIdx == CNT_W'(0)) cmdQ  <= busIn;
      if (byteIdx == CNT_W'(1)) addrQ <= busIn;
      for (int i = 0; i < WORD_BYTES; i++) begin
        if (byteIdx == CNT_W'(i + 2)) wdataQ[8*i +: 8] <= busIn;
      end
    end
  end

  assign cmdKnown = (cmdQ == CMD_READ) || (cmdQ == CMD_WRITE);

  always_comb begin
    unique case (cmdQ)
      CMD_READ:  dataNext = regRdData;
      CMD_WRITE: dataNext = wdataQ;
      default:   dataNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             dataWord <= '0;
    else if (strobe.access) dataWord <= dataNext;
  end

  generate
    if (STATUS_EN != 0) begin : g_status
      logic [DW-1:0] statusWord;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             statusWord <= '0;
        else if (strobe.access) statusWord <= cmdKnown ? regStatus : '0;
      end
      assign replyAll = {statusWord, dataWord};
    end else begin : g_nostatus
      assign replyAll = dataWord;
    end
  endgenerate

  always_comb begin
    busOut = '0;
    for (int i = 0; i < RD_BYTES; i++) begin
      if (byteIdx == CNT_W'(i)) busOut = replyAll[8*i +: 8];
    end
  end

  assign regAddr   = addrQ;
  assign regWrData = wdataQ;
  assign regWr     = strobe.access & (cmdQ == CMD_WRITE);
  assign regRd     = strobe.access & (cmdQ == CMD_READ);

  // R2
  single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({regWr, regRd}));

  // R2
  write_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regWr |=> !regWr);

  // R3
  read_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regRd |=> !regRd);

  // R10
  unknown_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.access && !cmdKnown) |-> (!regWr && !regRd));

endmodule

// File: rtl/byteBusSlave.sv
module byteBusSlave
  import byteBusPkg::*;
#(
  parameter int WORD_BYTES  = 4,
  parameter int STATUS_EN   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hostStart,
  input  logic                    hostRw,
  input  logic                    hostHs1,
  input  logic                    hostReset,
  input  logic [7:0]              busIn,
  output logic [7:0]              busOut,
  output logic                    busOe,
  output logic                    hostHs2,
  output logic                    hostAck,
  output logic [7:0]              regAddr,
  output logic [8*WORD_BYTES-1:0] regWrData,
  output logic                    regWr,
  output logic                    regRd,
  input  logic [8*WORD_BYTES-1:0] regRdData,
  input  logic [8*WORD_BYTES-1:0] regStatus
);

  localparam int WR_BYTES = 2 + WORD_BYTES;
  localparam int RD_BYTES = WORD_BYTES * ((STATUS_EN != 0) ? 2 : 1);
  localparam int MAX_B    = (WR_BYTES > RD_BYTES) ? WR_BYTES : RD_BYTES;
  localparam int CNT_W    = $clog2(MAX_B);

  logic [3:0]       syncVec;
  logic [CNT_W-1:0] byteIdx;
  strobeT           strobe;

  byteBusSync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn ({hostReset, hostHs1, hostRw, hostStart}),
    .syncOut (syncVec)
  );

  byteBusCtrl #(.WR_BYTES(WR_BYTES), .RD_BYTES(RD_BYTES), .CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .startS  (syncVec[0]),
    .rwS     (syncVec[1]),
    .hs1S    (syncVec[2]),
    .resetS  (syncVec[3]),
    .hs2     (hostHs2),
    .ack     (hostAck),
    .busOe   (busOe),
    .byteIdx (byteIdx),
    .strobe  (strobe)
  );

  byteBusData #(.WORD_BYTES(WORD_BYTES), .STATUS_EN(STATUS_EN),
                .RD_BYTES(RD_BYTES), .CNT_W(CNT_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .byteIdx   (byteIdx),
    .busIn     (busIn),
    .busOut    (busOut),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regWr     (regWr),
    .regRd     (regRd),
    .regRdData (regRdData),
    .regStatus (regStatus)
  );

endmodule

// File: tb/byteBusSlave_tb.sv
`timescale 1ns/1ps
module byteBusSlave_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, startA, startB, rw, hs1, hostRst, sel;
  logic [7:0]  busIn;
  logic [7:0]  busOutA, busOutB, regAddrA, regAddrB;
  logic        oeA, oeB, hs2A, hs2B, ackA, ackB;
  logic [31:0] wrDataA, wrDataB;
  logic        regWrA, regRdA, regWrB, regRdB;
  logic [31:0] rdDataA, rdDataB;
  logic [31:0] statusVal;

  assign rdDataA = {8'hC3, ~regAddrA, 8'h5A, regAddrA};
  assign rdDataB = {8'hC3, ~regAddrB, 8'h5A, regAddrB};

  byteBusSlave #(.STATUS_EN(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .hostStart(startA), .hostRw(rw), .hostHs1(hs1),
    .hostReset(hostRst), .busIn(busIn), .busOut(busOutA), .busOe(oeA),
    .hostHs2(hs2A), .hostAck(ackA), .regAddr(regAddrA), .regWrData(wrDataA),
    .regWr(regWrA), .regRd(regRdA), .regRdData(rdDataA), .regStatus(statusVal));

  byteBusSlave #(.STATUS_EN(0)) u_dutShort (
    .clk(clk), .rst_n(rst_n), .hostStart(startB), .hostRw(rw), .hostHs1(hs1),
    .hostReset(hostRst), .busIn(busIn), .busOut(busOutB), .busOe(oeB),
    .hostHs2(hs2B), .hostAck(ackB), .regAddr(regAddrB), .regWrData(wrDataB),
    .regWr(regWrB), .regRd(regRdB), .regRdData(rdDataB), .regStatus(statusVal));

  wire       hs2Sel = sel ? hs2B : hs2A;
  wire       ackSel = sel ? ackB : ackA;
  wire       oeSel  = sel ? oeB  : oeA;
  wire [7:0] outSel = sel ? busOutB : busOutA;

  int errors = 0;
  int checks = 0;
  int wrCount = 0, rdCount = 0, wrPulseLen = 0;
  logic [7:0]  wrAddrLog;
  logic [31:0] wrDataLog;

  always @(posedge clk) begin
    if (regWrA) begin
      wrCount   <= wrCount + 1;
      wrAddrLog <= regAddrA;
      wrDataLog <= wrDataA;
    end
    if (regRdA || regRdB) rdCount <= rdCount + 1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitHs2(input logic v);
    int n = 0;
    while (hs2Sel !== v && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk("R7 hs2 response", {63'd0, hs2Sel}, {63'd0, v});
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    busIn = b;
    hs1   = 1'b1;
    @(negedge clk);
    chk("R7 hs2 not early", {63'd0, hs2Sel}, 64'd0);
    chk("R9 no drive in command phase", {63'd0, oeSel}, 64'd0);
    waitHs2(1'b1);
    @(negedge clk);
    hs1 = 1'b0;
    waitHs2(1'b0);
  endtask

  task automatic readByte(output logic [7:0] b);
    @(negedge clk);
    hs1 = 1'b1;
    waitHs2(1'b1);
    b = outSel;
    chk("R9 drive in reply phase", {63'd0, oeSel}, 64'd1);
    chk("R8 ack low during reply", {63'd0, ackSel}, 64'd0);
    @(negedge clk);
    hs1 = 1'b0;
    waitHs2(1'b0);
  endtask

  task automatic openTxn();
    @(negedge clk);
    rw = 1'b1;
    if (sel) startB = 1'b1; else startA = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic closeTxn();
    @(negedge clk);
    startA = 1'b0;
    startB = 1'b0;
    rw     = 1'b1;
    repeat (6) @(negedge clk);
    chk("R8 ack cleared after start drop", {63'd0, ackSel}, 64'd0);
    chk("R9 no drive when idle", {63'd0, oeSel}, 64'd0);
  endtask

  task automatic txn(input logic [7:0] cmd, input logic [7:0] addr, input logic [31:0] data,
                     input int nReply, output logic [63:0] got);
    logic [7:0] b;
    got = '0;
    openTxn();
    sendByte(cmd);
    sendByte(addr);
    for (int i = 0; i < 4; i++) sendByte(data[8*i +: 8]);
    repeat (5) @(negedge clk);
    chk("R9 no drive while host writes", {63'd0, oeSel}, 64'd0);
    rw = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 drive after host reads", {63'd0, oeSel}, 64'd1);
    for (int i = 0; i < nReply; i++) begin
      readByte(b);
      got[8*i +: 8] = b;
    end
    repeat (2) @(negedge clk);
    chk("R8 ack after final byte", {63'd0, ackSel}, 64'd1);
    closeTxn();
  endtask

  task automatic tReset();
    chk("R1 hs2 idle", {63'd0, hs2A}, 64'd0);
    chk("R1 ack idle", {63'd0, ackA}, 64'd0);
    chk("R1 oe idle", {63'd0, oeA}, 64'd0);
    chk("R1 no strobes", 64'(wrCount + rdCount), 64'd0);
  endtask

  task automatic tRead();
    logic [63:0] got;
    int w0 = wrCount, r0 = rdCount;
    sel = 1'b0;
    txn(8'h00, 8'h21, 32'hFFFF_FFFF, 8, got);
    chk("R3 read reply word", {32'd0, got[31:0]}, {32'd0, 32'hC3DE_5A21});
    chk("R5 status word", {32'd0, got[63:32]}, {32'd0, statusVal});
    chk("R3 one read strobe", 64'(rdCount - r0), 64'd1);
    chk("R3 no write strobe", 64'(wrCount - w0), 64'd0);
  endtask

  task automatic tWrite();
    logic [63:0] got;
    int w0 = wrCount, r0 = rdCount;
    sel = 1'b0;
    txn(8'h01, 8'h44, 32'h1234_ABCD, 8, got);
    chk("R2 one write strobe", 64'(wrCount - w0), 64'd1);
    chk("R2 no read strobe", 64'(rdCount - r0), 64'd0);
    chk("R2 write address", {56'd0, wrAddrLog}, {56'd0, 8'h44});
    chk("R2 write data order", {32'd0, wrDataLog}, {32'd0, 32'h1234_ABCD});
    chk("R4 write echo", {32'd0, got[31:0]}, {32'd0, 32'h1234_ABCD});
    chk("R5 status after write", {32'd0, got[63:32]}, {32'd0, statusVal});
  endtask

  task automatic tShort();
    logic [63:0] got;
    sel = 1'b1;
    txn(8'h00, 8'h0F, 32'h0, 4, got);
    chk("R6 four byte reply", got, {32'd0, 32'hC3F0_5A0F});
    sel = 1'b0;
  endtask

  task automatic tUnknown();
    logic [63:0] got;
    int w0 = wrCount, r0 = rdCount;
    sel = 1'b0;
    txn(8'h7E, 8'h33, 32'h5555_AAAA, 8, got);
    chk("R10 no strobes", 64'((wrCount - w0) + (rdCount - r0)), 64'd0);
    chk("R10 zero reply", got, 64'd0);
  endtask

  task automatic tAbort();
    int w0 = wrCount, r0 = rdCount;
    sel = 1'b0;
    openTxn();
    sendByte(8'h01);
    sendByte(8'h50);
    sendByte(8'h99);
    @(negedge clk);
    startA = 1'b0;
    repeat (8) @(negedge clk);
    chk("R11 hs2 low after abort", {63'd0, hs2A}, 64'd0);
    chk("R11 no access after abort", 64'((wrCount - w0) + (rdCount - r0)), 64'd0);
    tRead();
  endtask

  task automatic tHostReset();
    int w0 = wrCount, r0 = rdCount;
    sel = 1'b0;
    openTxn();
    sendByte(8'h01);
    @(negedge clk);
    busIn = 8'h62;
    hs1   = 1'b1;
    waitHs2(1'b1);
    @(negedge clk);
    hostRst = 1'b1;
    repeat (6) @(negedge clk);
    chk("R12 hs2 forced low", {63'd0, hs2A}, 64'd0);
    chk("R12 ack low", {63'd0, ackA}, 64'd0);
    chk("R12 oe low", {63'd0, oeA}, 64'd0);
    hs1    = 1'b0;
    startA = 1'b0;
    repeat (2) @(negedge clk);
    hostRst = 1'b0;
    repeat (6) @(negedge clk);
    chk("R12 no access", 64'((wrCount - w0) + (rdCount - r0)), 64'd0);
    tRead();
  endtask

  initial begin
    rst_n = 1'b0; startA = 1'b0; startB = 1'b0; rw = 1'b1; hs1 = 1'b0;
    hostRst = 1'b0; sel = 1'b0; busIn = 8'h00; statusVal = 32'h9A0F_3C11;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tReset();
    tRead();
    tWrite();
    statusVal = 32'h0BAD_F00D;
    tRead();
    tShort();
    tUnknown();
    tAbort();
    tHostReset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R7 watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule